// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This always-on controller moves a processor subsystem between four power modes of increasing depth. Software programs a target mode. When the core signals that it has gone to sleep, the controller gates one of three clock sets. The lightest mode gates only the core clock. The middle mode also gates the system bus clock and the peripheral bus clock. The deepest mode also stops the interrupt-controller clock, puts sequential state into retention and removes power from combinational logic.

An accepted wake event returns the subsystem to the active mode. A wake event counts only when its source is unmasked and is allowed in the current mode. In the deepest mode only a fixed subset of sources is allowed. If the core went to sleep from inside an interrupt handler, only wake events flagged as higher priority count. Leaving the deepest mode follows a fixed order:

1. Power is restored.
2. Retention is released.
3. The clocks come back in the reverse of the order in which they were gated.

A sticky debug hold blocks entry into every low-power mode. Only a power-on reset clears it; the ordinary system reset does not.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the current-mode output `cur_mode` reads 0 (active). All four clock enables read 1, `retain` reads 0 and `comb_pwr_en` reads 1. The target register resets to 0 and the wake mask resets to all ones (all sources unmasked).
- R2: The controller leaves active mode only when all of the following hold at a clock edge: the target register is nonzero, `core_sleeping` is 1 and the debug hold is clear. The new mode's outputs appear after that edge. Entry clears the target register to 0, unless a mode write lands in the same cycle. Writing 0 while active leaves the controller in mode 0.
- R3: In mode 1 (`cur_mode`=1) only `core_clk_en` is 0. The system bus, peripheral bus and interrupt-controller clock enables stay 1, with `retain`=0 and `comb_pwr_en`=1.
- R4: In mode 2 (`cur_mode`=2), `core_clk_en`, `hclk_en` and `pclk_en` are 0. `fclk_en` stays 1.
- R5: In mode 3 (`cur_mode`=3, resting), all four clock enables are 0, `retain`=1 and `comb_pwr_en`=0.
- R6: In mode 1 or mode 2, an accepted wake at a clock edge returns all outputs to the R1 active values after that edge.
- R7: In resting mode 3, a wake source i counts only if bit i of parameter `HIB_WAKE_ALLOW` is 1 (default 0x0F, sources 0 to 3). Events on any other source leave every output unchanged.
- R8: Wake source i is accepted only if bit i of the wake mask is 1. The wake mask is written through `mask_we`/`mask_wdata`.
- R9: An accepted wake in resting mode 3 starts a fixed exit. Each of the following steps lasts one cycle, with `cur_mode` reading 3 throughout:
  - power on with retain still 1;
  - retain released;
  - `fclk_en` on;
  - `hclk_en` and `pclk_en` on.
  After the last step the controller is active with `core_clk_en` 1.
- R10: A pulse on `dbg_hold_set` sets a hold that blocks entry from the following cycle onward. The hold survives `rst_n` and is cleared only by `por_n`.
- R11: If `in_handler` was 1 at the entry edge, a wake on source i is accepted only while `wake_hi_pri[i]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| rst_n | input | 1 | System reset, active low, asynchronous; leaves the debug hold |
| mode_we | input | 1 | Target-mode write strobe |
| mode_wdata | input | 2 | Target mode: 0 active, 1 core sleep, 2 system sleep, 3 hibernate |
| mask_we | input | 1 | Wake-mask write strobe |
| mask_wdata | input | NW | Wake-mask value, 1 = source enabled |
| core_sleeping | input | 1 | Core reports it has entered sleep |
| in_handler | input | 1 | Core is inside an interrupt handler |
| dbg_hold_set | input | 1 | Debug requests the low-power hold |
| wake_evt | input | NW | Wake event per source |
| wake_hi_pri | input | NW | Per-source flag: event outranks the current handler |
| core_clk_en | output | 1 | Core clock enable |
| hclk_en | output | 1 | System bus clock enable |
| pclk_en | output | 1 | Peripheral bus clock enable |
| fclk_en | output | 1 | Interrupt-controller clock enable |
| retain | output | 1 | Sequential-state retention control |
| comb_pwr_en | output | 1 | Combinational-logic power enable |
| cur_mode | output | 2 | Current mode status |

## Verification
Every output is decoded from one registered state. A wrong state therefore shows on the enables, `retain`, `comb_pwr_en` or `cur_mode` one edge after the stimulus that caused it. A lost target or mask write, a missed debug hold, or a wrongly latched handler flag shows later, at the next sleep entry or wake attempt, as a mode that fails to change or changes when it should not. The reference model compares all eight output bits at every falling edge, so any such slip is caught in the first cycle where it reaches a port.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [2:0] {
    ST_ACT   = 3'd0,
    ST_CSLP  = 3'd1,
    ST_SSLP  = 3'd2,
    ST_HIB   = 3'd3,
    ST_XPWR  = 3'd4,
    ST_XRET  = 3'd5,
    ST_XNVIC = 3'd6,
    ST_XBUS  = 3'd7
  } pms_state_e;

  typedef struct packed {
    logic       core;
    logic       hbus;
    logic       pbus;
    logic       nvic;
    logic       retain;
    logic       pwr;
    logic [1:0] mode;
  } pms_ctl_t;

  // Output decode for every state; exit steps report mode 3.
  function automatic pms_ctl_t pms_decode(pms_state_e s);
    pms_ctl_t c;
    case (s)
      ST_ACT:   c = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0};
      ST_CSLP:  c = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1};
      ST_SSLP:  c = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2};
      ST_HIB:   c = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3};
      ST_XPWR:  c = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd3};
      ST_XRET:  c = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3};
      ST_XNVIC: c = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd3};
      default:  c = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd3};
    endcase
    return c;
  endfunction

  // Low-power state selected by a nonzero target value.
  function automatic pms_state_e pms_entry_state(logic [1:0] tgt);
    return pms_state_e'({1'b0, tgt});
  endfunction

endpackage

// File: rtl/pms_cfg_regs.sv
module pms_cfg_regs #(
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          sys_rst_n,
  input  logic          mode_we,
  input  logic [1:0]    mode_wdata,
  input  logic          mask_we,
  input  logic [NW-1:0] mask_wdata,
  input  logic          consume,
  input  logic          dbg_hold_set,
  output logic [1:0]    target_q,
  output logic [NW-1:0] mask_q,
  output logic          hold_q
);

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      target_q <= 2'd0;
      mask_q   <= '1;
    end else begin
      if (mode_we)      target_q <= mode_wdata;
      else if (consume) target_q <= 2'd0;
      if (mask_we)      mask_q   <= mask_wdata;
    end
  end

  // Debug hold: only the power-on reset clears it.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)            hold_q <= 1'b0;
    else if (dbg_hold_set) hold_q <= 1'b1;
  end

endmodule

// File: rtl/pms_wake_qual.sv
module pms_wake_qual
  import pms_pkg::*;
#(
  parameter int            NW             = 8,
  parameter logic [NW-1:0] HIB_WAKE_ALLOW = 'h0F
) (
  input  pms_state_e    state,
  input  logic [NW-1:0] wake_evt,
  input  logic [NW-1:0] wake_hi_pri,
  input  logic [NW-1:0] mask_q,
  input  logic          isr_q,
  output logic          wake_ok
);

  logic [NW-1:0] mode_allow;
  logic [NW-1:0] pri_allow;
  logic [NW-1:0] eligible;
  logic          resting;

  always_comb begin
    mode_allow = (state == ST_HIB) ? HIB_WAKE_ALLOW : {NW{1'b1}};
    pri_allow  = isr_q ? wake_hi_pri : {NW{1'b1}};
    eligible   = wake_evt & mask_q & mode_allow & pri_allow;
    resting    = (state == ST_CSLP) || (state == ST_SSLP) || (state == ST_HIB);
    wake_ok    = resting && (|eligible);
  end

endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
  import pms_pkg::*;
(
  input  logic       clk,
  input  logic       sys_rst_n,
  input  logic [1:0] target_q,
  input  logic       core_sleeping,
  input  logic       hold_q,
  input  logic       in_handler,
  input  logic       wake_ok,
  output pms_state_e state,
  output logic       isr_q,
  output logic       consume
);

  pms_state_e nxt;

  assign consume = (state == ST_ACT) && (target_q != 2'd0) && core_sleeping && !hold_q;

  always_comb begin
    nxt = state;
    case (state)
      ST_ACT:   if (consume) nxt = pms_entry_state(target_q);
      ST_CSLP,
      ST_SSLP:  if (wake_ok) nxt = ST_ACT;
      ST_HIB:   if (wake_ok) nxt = ST_XPWR;
      ST_XPWR:  nxt = ST_XRET;
      ST_XRET:  nxt = ST_XNVIC;
      ST_XNVIC: nxt = ST_XBUS;
      default:  nxt = ST_ACT;
    endcase
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      state <= ST_ACT;
      isr_q <= 1'b0;
    end else begin
      state <= nxt;
      if (consume) isr_q <= in_handler;
    end
  end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int            NW             = 8,
  parameter logic [NW-1:0] HIB_WAKE_ALLOW = 'h0F
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          mode_we,
  input  logic [1:0]    mode_wdata,
  input  logic          mask_we,
  input  logic [NW-1:0] mask_wdata,
  input  logic          core_sleeping,
  input  logic          in_handler,
  input  logic          dbg_hold_set,
  input  logic [NW-1:0] wake_evt,
  input  logic [NW-1:0] wake_hi_pri,
  output logic          core_clk_en,
  output logic          hclk_en,
  output logic          pclk_en,
  output logic          fclk_en,
  output logic          retain,
  output logic          comb_pwr_en,
  output logic [1:0]    cur_mode
);

  logic          sys_rst_n;
  logic [1:0]    target_q;
  logic [NW-1:0] mask_q;
  logic          hold_q;
  logic          consume;
  logic          wake_ok;
  logic          isr_q;
  pms_state_e    state;
  pms_ctl_t      ctl;

  assign sys_rst_n = por_n & rst_n;

  pms_cfg_regs #(.NW(NW)) u_cfg (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .consume(consume), .dbg_hold_set(dbg_hold_set),
    .target_q(target_q), .mask_q(mask_q), .hold_q(hold_q)
  );

  pms_wake_qual #(.NW(NW), .HIB_WAKE_ALLOW(HIB_WAKE_ALLOW)) u_wake (
    .state(state), .wake_evt(wake_evt), .wake_hi_pri(wake_hi_pri),
    .mask_q(mask_q), .isr_q(isr_q), .wake_ok(wake_ok)
  );

  pms_fsm u_fsm (
    .clk(clk), .sys_rst_n(sys_rst_n), .target_q(target_q),
    .core_sleeping(core_sleeping), .hold_q(hold_q), .in_handler(in_handler),
    .wake_ok(wake_ok), .state(state), .isr_q(isr_q), .consume(consume)
  );

  assign ctl         = pms_decode(state);
  assign core_clk_en = ctl.core;
  assign hclk_en     = ctl.hbus;
  assign pclk_en     = ctl.pbus;
  assign fclk_en     = ctl.nvic;
  assign retain      = ctl.retain;
  assign comb_pwr_en = ctl.pwr;
  assign cur_mode    = ctl.mode;

endmodule

// File: rtl/pms_chk.sv
module pms_chk (
  input logic       clk,
  input logic       sys_rst_n,
  input logic       core_sleeping,
  input logic       hold_q,
  input logic       wake_ok,
  input logic       core_clk_en,
  input logic       hclk_en,
  input logic       pclk_en,
  input logic       fclk_en,
  input logic       retain,
  input logic       comb_pwr_en,
  input logic [1:0] cur_mode
);

  // R2
  core_gate_after_sleep_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $fell(core_clk_en) |-> $past(core_sleeping) && !$past(hold_q));

  // R4
  bus_pair_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    hclk_en == pclk_en);

  // R5
  nvic_stop_deep_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !fclk_en |-> cur_mode == 2'd3);

  // R6
  light_wake_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    wake_ok && (cur_mode != 2'd3) |=> cur_mode == 2'd0 && core_clk_en);

  // R9
  retain_release_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $fell(retain) |-> $past(comb_pwr_en));

  // R9
  deep_wake_pwr_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    wake_ok && retain |=> comb_pwr_en && retain);

  // R9
  core_last_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $rose(core_clk_en) |-> hclk_en && fclk_en && comb_pwr_en);

  // R10
  hold_blocks_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    hold_q && cur_mode == 2'd0 |=> cur_mode == 2'd0);

endmodule

bind pwr_mode_seq pms_chk u_pms_chk (
  .clk(clk), .sys_rst_n(sys_rst_n), .core_sleeping(core_sleeping),
  .hold_q(hold_q), .wake_ok(wake_ok), .core_clk_en(core_clk_en),
  .hclk_en(hclk_en), .pclk_en(pclk_en), .fclk_en(fclk_en),
  .retain(retain), .comb_pwr_en(comb_pwr_en), .cur_mode(cur_mode)
);

// File: tb/pwr_mode_seq_test.sv
module pwr_mode_seq_test;

  localparam int NW = 8;
  localparam logic [NW-1:0] HIB_OK = 8'h0F;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0;
  logic mode_we = 1'b0, mask_we = 1'b0;
  logic [1:0] mode_wdata = 2'd0;
  logic [NW-1:0] mask_wdata = '0;
  logic core_sleeping = 1'b0, in_handler = 1'b0, dbg_hold_set = 1'b0;
  logic [NW-1:0] wake_evt = '0, wake_hi_pri = '0;
  logic core_clk_en, hclk_en, pclk_en, fclk_en, retain, comb_pwr_en;
  logic [1:0] cur_mode;

  int vectors = 0, miscompares = 0, cyc = 0;
  bit chk_on = 1'b0;
  string tag = "R1";

  always #4 clk = ~clk;

  pwr_mode_seq #(.NW(NW), .HIB_WAKE_ALLOW(HIB_OK)) uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .mode_we(mode_we),
    .mode_wdata(mode_wdata), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .core_sleeping(core_sleeping), .in_handler(in_handler),
    .dbg_hold_set(dbg_hold_set), .wake_evt(wake_evt), .wake_hi_pri(wake_hi_pri),
    .core_clk_en(core_clk_en), .hclk_en(hclk_en), .pclk_en(pclk_en),
    .fclk_en(fclk_en), .retain(retain), .comb_pwr_en(comb_pwr_en),
    .cur_mode(cur_mode)
  );

  // Reference model: phase 0 active, 1..3 resting depth, 10..13 deep-exit steps.
  int m_phase = 0;
  logic [1:0] m_tgt = 2'd0;
  logic [NW-1:0] m_mask = '1;
  bit m_hold = 1'b0, m_isr = 1'b0;

  always @(posedge clk or negedge por_n or negedge rst_n) begin
    if (!por_n) begin
      m_phase = 0; m_tgt = 0; m_mask = '1; m_hold = 0; m_isr = 0;
    end else if (!rst_n) begin
      m_phase = 0; m_tgt = 0; m_mask = '1; m_isr = 0;
    end else begin
      bit go, woke;
      go = (m_phase == 0) && (m_tgt != 0) && core_sleeping && !m_hold;
      woke = 0;
      for (int k = 0; k < NW; k++)
        if (wake_evt[k] && m_mask[k] && (m_phase != 3 || HIB_OK[k]) && (!m_isr || wake_hi_pri[k]))
          woke = 1;
      if (go) begin m_phase = int'(m_tgt); m_isr = in_handler; end
      else if ((m_phase == 1 || m_phase == 2) && woke) m_phase = 0;
      else if (m_phase == 3 && woke) m_phase = 10;
      else if (m_phase >= 10) m_phase = (m_phase == 13) ? 0 : m_phase + 1;
      if (mode_we) m_tgt = mode_wdata; else if (go) m_tgt = 0;
      if (mask_we) m_mask = mask_wdata;
      if (dbg_hold_set) m_hold = 1;
    end
  end

  function automatic logic [7:0] expect_vec(int ph);
    // {core,hbus,pbus,nvic,retain,pwr,mode[1:0]}
    case (ph)
      0: return 8'b1111_0100;
      1: return 8'b0111_0101;
      2: return 8'b0001_0110;
      3: return 8'b0000_1011;
      10: return 8'b0000_1111;
      11: return 8'b0000_0111;
      12: return 8'b0001_0111;
      default: return 8'b0111_0111;
    endcase
  endfunction

  always @(negedge clk) if (chk_on) begin
    logic [7:0] act, exv;
    act = {core_clk_en, hclk_en, pclk_en, fclk_en, retain, comb_pwr_en, cur_mode};
    exv = expect_vec(m_phase);
    vectors++;
    if (act !== exv) begin
      miscompares++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exv);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected<150000 cycles", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_mode(logic [1:0] v);
    mode_we = 1; mode_wdata = v; cycles(1); mode_we = 0;
  endtask

  task automatic wr_mask(logic [NW-1:0] v);
    mask_we = 1; mask_wdata = v; cycles(1); mask_we = 0;
  endtask

  task automatic wake(logic [NW-1:0] b, logic [NW-1:0] hi);
    wake_evt = b; wake_hi_pri = hi; cycles(1); wake_evt = '0; wake_hi_pri = '0;
  endtask

  initial begin
    // R1 reset state
    cycles(2); chk_on = 1; por_n = 1; rst_n = 1; cycles(3);
    // R2 writing 0 while active, sleeping: stays active
    tag = "R2"; core_sleeping = 1; wr_mode(2'd0); cycles(3);
    core_sleeping = 0; wr_mode(2'd1); cycles(3);
    // R3 core sleep entry, R6 wake back
    tag = "R3"; core_sleeping = 1; cycles(1); core_sleeping = 0; cycles(3);
    tag = "R6"; wake(8'h20, 8'h00); cycles(2);
    // R8 masked source ignored; R4 system sleep
    tag = "R8"; wr_mask(8'hFB); wr_mode(2'd2); core_sleeping = 1; cycles(1);
    core_sleeping = 0; cycles(2);
    wake(8'h04, 8'h00); cycles(2);
    tag = "R4"; cycles(2); wake(8'h10, 8'h00); cycles(2);
    // R5 hibernate, R7 disallowed source, R9 ordered exit
    tag = "R5"; wr_mask(8'hFF); wr_mode(2'd3); core_sleeping = 1; cycles(1);
    core_sleeping = 0; cycles(3);
    tag = "R7"; wake(8'h40, 8'h00); wake(8'hF0, 8'hFF); cycles(2);
    tag = "R9"; wake(8'h02, 8'h00); cycles(7);
    // R11 handler entry: only flagged sources exit
    tag = "R11"; wr_mode(2'd1); in_handler = 1; core_sleeping = 1; cycles(1);
    in_handler = 0; core_sleeping = 0; cycles(2);
    wake(8'h08, 8'h00); cycles(2); wake(8'h08, 8'h08); cycles(2);
    // R10 debug hold sticky across rst_n, cleared by por_n
    tag = "R10"; dbg_hold_set = 1; cycles(1); dbg_hold_set = 0;
    wr_mode(2'd2); core_sleeping = 1; cycles(4);
    core_sleeping = 0; rst_n = 0; cycles(1); rst_n = 1; cycles(1);
    wr_mode(2'd2); core_sleeping = 1; cycles(4);
    core_sleeping = 0; por_n = 0; cycles(1); por_n = 1; cycles(1);
    wr_mode(2'd2); core_sleeping = 1; cycles(1); core_sleeping = 0; cycles(2);
    wake(8'h01, 8'h00); cycles(2);
    // Mixed stimulus across all requirements
    tag = "R2/R6/R7/R8/R9/R11 mixed";
    for (int i = 0; i < 3000; i++) begin
      core_sleeping = ($urandom_range(0, 3) == 0);
      in_handler    = $urandom_range(0, 1);
      wake_evt      = ($urandom_range(0, 5) == 0) ? NW'($urandom) : '0;
      wake_hi_pri   = NW'($urandom);
      mode_we       = ($urandom_range(0, 7) == 0);
      mode_wdata    = 2'($urandom);
      mask_we       = ($urandom_range(0, 31) == 0);
      mask_wdata    = NW'($urandom);
      rst_n         = ($urandom_range(0, 499) != 0);
      cycles(1);
    end
    rst_n = 1; mode_we = 0; mask_we = 0; wake_evt = '0; core_sleeping = 0;
    cycles(2);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule